// File: doc/BRIEF.md
# Alternating-Channel Sample Capture Controller

This block records a parallel input bus, one word on every clock, after a start delay that software sets. It groups the words into buffers of a fixed byte size and hands each full buffer to one of two downstream channels in turn. While one channel drains a finished buffer, the other one receives the next buffer. Each captured word leaves on a push strobe. The strobe carries the channel number and a flag that marks the last word of a buffer.

A start pulse latches the sample width and the delay, then launches a capture run. The run continues until a stop pulse arrives or until the channel that is due to receive a word reports that it is not ready. In the second case the block halts in a done state and raises an overflow flag. The start delay has three separate entry paths: zero cycles, one cycle, and two or more cycles. On the zero-cycle path the entry state takes the first sample itself, so the capture loop that follows needs one sample fewer for the first buffer.

Top module: `pingpong_capture`

## Requirements
- R1: After reset, `push_o`, `done_o` and `overflow_o` are low, and they stay low until a start pulse.
- R2: `cfg_width_i` encodes the sample width as (bytes − 1). A pushed word holds the low (`cfg_width_i`+1) bytes of `din_i`, and every byte above them is zero.
- R3: Every buffer holds exactly `BUF_BYTES`/(`cfg_width_i`+1) words. `buf_end_o` is high together with the last word of each buffer and low on every other word. `BUF_BYTES` must be a multiple of 12 so that the division is exact for every width up to four bytes.
- R4: The first buffer after a start goes to channel 0 (`push_chan_o` = 0). Later buffers alternate 1, 0, 1, …, and the channel changes only across a buffer end.
- R5: With delay 0, the first word pushed is the `din_i` value present at the first clock edge after the edge that samples start.
- R6: With delay 1, the first word pushed is the `din_i` value present at the second clock edge after the start edge.
- R7: With a delay D of 2 or more, the first word pushed is the `din_i` value present at clock edge D+1 after the start edge.
- R8: If the ready bit of the active channel is low at an edge where a word is due, no word is pushed at that edge. From then on `done_o` and `overflow_o` are high and no further word is pushed.
- R9: A stop pulse makes `done_o` high at the next edge and suppresses all later pushes. This also holds during the delay. `overflow_o` stays low in this case.
- R10: A start pulse clears `done_o` and `overflow_o` and begins a new run from the delay entry path on channel 0. This also holds after an overflow.
- R11: During a run, words are pushed on every clock without gaps. Consecutive words come from consecutive `din_i` values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse: latch configuration and begin a run |
| stop_i | input | 1 | One-cycle pulse: halt capture (has priority over start) |
| cfg_width_i | input | WC_W | Sample width code, bytes − 1 |
| cfg_delay_i | input | DELAY_W | Start delay in clock cycles |
| din_i | input | 8*MAX_BYTES | Sampled data bus |
| chan_ready_i | input | 2 | Ready flag per downstream channel, bit n is channel n |
| push_o | output | 1 | One-cycle strobe: a word is valid |
| push_data_o | output | 8*MAX_BYTES | Captured word, zero above the active width |
| push_chan_o | output | 1 | Channel that receives the word |
| buf_end_o | output | 1 | High with the last word of a buffer |
| done_o | output | 1 | Capture has halted |
| overflow_o | output | 1 | The halt was caused by a channel that was not ready |

## Verification
The bench builds the block with `MAX_BYTES` = 4 and `BUF_BYTES` = 24 instead of 6144. With these values a buffer holds 24, 12, 8 or 6 words depending on the width, so a short run crosses several buffer ends and several channel swaps for widths of one, two, three and four bytes. A 16-bit delay field makes each of the three entry paths reachable, with delays of 0, 1, 2 and 5, and also a long delay of 20 that a stop cuts short. The input bus carries a word derived from a cycle counter, so the position of each captured word in time can be read from its value.

// File: rtl/pp_cap_pkg.sv
package pp_cap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_WAIT,
        ST_CAP,
        ST_DONE
    } cap_state_e;

    function automatic int unsigned wcode_bits(int unsigned max_bytes);
        return (max_bytes > 1) ? $clog2(max_bytes) : 1;
    endfunction

endpackage

// File: rtl/pp_cap_cfg.sv
module pp_cap_cfg #(
    parameter int unsigned MAX_BYTES = 4,
    parameter int unsigned BUF_BYTES = 6144,
    parameter int unsigned DELAY_W   = 16,
    localparam int unsigned DATA_W   = 8 * MAX_BYTES,
    localparam int unsigned WC_W     = pp_cap_pkg::wcode_bits(MAX_BYTES),
    localparam int unsigned SC_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [WC_W-1:0]    width_i,
    input  logic [DELAY_W-1:0] delay_i,
    output logic [SC_W-1:0]    last_idx_o,
    output logic [DATA_W-1:0]  mask_o,
    output logic [DELAY_W-1:0] delay_o
);

    typedef struct packed {
        logic [SC_W-1:0]    last_idx;
        logic [DATA_W-1:0]  mask;
        logic [DELAY_W-1:0] delay;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [SC_W-1:0]   last_tab [MAX_BYTES];
    logic [DATA_W-1:0] mask_tab [MAX_BYTES];
    logic [WC_W-1:0]   sel;

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_width
        assign last_tab[g] = SC_W'(BUF_BYTES / (g + 1) - 1);
        for (genvar b = 0; b < MAX_BYTES; b++) begin : g_lane
            assign mask_tab[g][8*b +: 8] = (b <= g) ? 8'hFF : 8'h00;
        end
    end

    always_comb begin
        sel = width_i;
        if (32'(width_i) > MAX_BYTES - 1) begin
            sel = WC_W'(MAX_BYTES - 1);
        end
        cfg_d = cfg_q;
        if (start_i) begin
            cfg_d.last_idx = last_tab[sel];
            cfg_d.mask     = mask_tab[sel];
            cfg_d.delay    = delay_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign last_idx_o = cfg_q.last_idx;
    assign mask_o     = cfg_q.mask;
    assign delay_o    = cfg_q.delay;

    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(cfg_q.last_idx));

endmodule

// File: rtl/pp_cap_seq.sv
module pp_cap_seq
    import pp_cap_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 4,
    parameter int unsigned BUF_BYTES = 6144,
    parameter int unsigned DELAY_W   = 16,
    localparam int unsigned DATA_W   = 8 * MAX_BYTES,
    localparam int unsigned SC_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [SC_W-1:0]    last_idx_i,
    input  logic [DATA_W-1:0]  mask_i,
    input  logic [DELAY_W-1:0] delay_i,
    input  logic [DATA_W-1:0]  din_i,
    input  logic [1:0]         chan_ready_i,
    output logic               push_o,
    output logic [DATA_W-1:0]  push_data_o,
    output logic               push_chan_o,
    output logic               buf_end_o,
    output logic               done_o,
    output logic               overflow_o
);

    typedef struct packed {
        cap_state_e         state;
        logic [DELAY_W-1:0] dcnt;
        logic [SC_W-1:0]    scnt;
        logic               chan;
        logic               push;
        logic [DATA_W-1:0]  pdata;
        logic               pchan;
        logic               pend;
        logic               done;
        logic               ovf;
    } seq_t;

    seq_t seq_d, seq_q;
    logic ready_now;

    assign ready_now = chan_ready_i[seq_q.chan];

    always_comb begin
        seq_d      = seq_q;
        seq_d.push = 1'b0;
        seq_d.pend = 1'b0;

        if (stop_i) begin
            seq_d.state = ST_DONE;
            seq_d.done  = 1'b1;
        end else if (start_i) begin
            seq_d.state = ST_ARM;
            seq_d.done  = 1'b0;
            seq_d.ovf   = 1'b0;
            seq_d.scnt  = '0;
            seq_d.chan  = 1'b0;
        end else begin
            logic take;
            take = 1'b0;
            case (seq_q.state)
                ST_ARM: begin
                    if (delay_i == '0) begin
                        take = 1'b1;
                    end else if (delay_i == DELAY_W'(1)) begin
                        seq_d.state = ST_CAP;
                    end else begin
                        seq_d.dcnt  = delay_i - DELAY_W'(2);
                        seq_d.state = ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (seq_q.dcnt == '0) begin
                        seq_d.state = ST_CAP;
                    end else begin
                        seq_d.dcnt = seq_q.dcnt - DELAY_W'(1);
                    end
                end
                ST_CAP:  take = 1'b1;
                default: ;
            endcase

            if (take) begin
                if (!ready_now) begin
                    seq_d.state = ST_DONE;
                    seq_d.done  = 1'b1;
                    seq_d.ovf   = 1'b1;
                end else begin
                    seq_d.state = ST_CAP;
                    seq_d.push  = 1'b1;
                    seq_d.pdata = din_i & mask_i;
                    seq_d.pchan = seq_q.chan;
                    if (seq_q.scnt >= last_idx_i) begin
                        seq_d.pend = 1'b1;
                        seq_d.scnt = '0;
                        seq_d.chan = ~seq_q.chan;
                    end else begin
                        seq_d.scnt = seq_q.scnt + SC_W'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign push_o      = seq_q.push;
    assign push_data_o = seq_q.pdata;
    assign push_chan_o = seq_q.pchan;
    assign buf_end_o   = seq_q.pend;
    assign done_o      = seq_q.done;
    assign overflow_o  = seq_q.ovf;

    p_push_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.push |-> $past(ready_now));

    p_overflow_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.ovf |-> (seq_q.done && !seq_q.push));

    p_end_swaps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.push && seq_q.pend) |-> (seq_q.chan != seq_q.pchan));

    p_mid_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.push && !seq_q.pend) |-> (seq_q.chan == seq_q.pchan));

    p_start_chan0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> (!seq_q.chan && !seq_q.done && !seq_q.ovf));

    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (seq_q.done && !seq_q.push));

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.scnt <= last_idx_i);

endmodule

// File: rtl/pingpong_capture.sv
module pingpong_capture #(
    parameter int unsigned MAX_BYTES = 4,
    parameter int unsigned BUF_BYTES = 6144,
    parameter int unsigned DELAY_W   = 16,
    localparam int unsigned DATA_W   = 8 * MAX_BYTES,
    localparam int unsigned WC_W     = pp_cap_pkg::wcode_bits(MAX_BYTES),
    localparam int unsigned SC_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [WC_W-1:0]    cfg_width_i,
    input  logic [DELAY_W-1:0] cfg_delay_i,
    input  logic [DATA_W-1:0]  din_i,
    input  logic [1:0]         chan_ready_i,
    output logic               push_o,
    output logic [DATA_W-1:0]  push_data_o,
    output logic               push_chan_o,
    output logic               buf_end_o,
    output logic               done_o,
    output logic               overflow_o
);

    logic [SC_W-1:0]    last_idx;
    logic [DATA_W-1:0]  mask;
    logic [DELAY_W-1:0] delay;

    pp_cap_cfg #(
        .MAX_BYTES (MAX_BYTES),
        .BUF_BYTES (BUF_BYTES),
        .DELAY_W   (DELAY_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .width_i    (cfg_width_i),
        .delay_i    (cfg_delay_i),
        .last_idx_o (last_idx),
        .mask_o     (mask),
        .delay_o    (delay)
    );

    pp_cap_seq #(
        .MAX_BYTES (MAX_BYTES),
        .BUF_BYTES (BUF_BYTES),
        .DELAY_W   (DELAY_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .last_idx_i   (last_idx),
        .mask_i       (mask),
        .delay_i      (delay),
        .din_i        (din_i),
        .chan_ready_i (chan_ready_i),
        .push_o       (push_o),
        .push_data_o  (push_data_o),
        .push_chan_o  (push_chan_o),
        .buf_end_o    (buf_end_o),
        .done_o       (done_o),
        .overflow_o   (overflow_o)
    );

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !push_o);

endmodule

// File: tb/test_pingpong_capture.sv
`timescale 1ns/1ps
module test_pingpong_capture;

    localparam int unsigned MAX_BYTES = 4;
    localparam int unsigned BUF_BYTES = 24;
    localparam int unsigned DELAY_W   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        stop_i = 1'b0;
    logic [1:0]  cfg_width_i = '0;
    logic [15:0] cfg_delay_i = '0;
    logic [31:0] din_i;
    logic [1:0]  chan_ready_i = 2'b11;
    logic        push_o;
    logic [31:0] push_data_o;
    logic        push_chan_o;
    logic        buf_end_o;
    logic        done_o;
    logic        overflow_o;

    int unsigned cnt = 0;
    int          checks = 0;
    int          fails = 0;
    int          midx = 0;
    logic [31:0] mdata [0:511];
    logic        mchan [0:511];
    logic        mend  [0:511];

    always #4 clk = ~clk;

    function automatic logic [31:0] pattern(int unsigned c);
        return c * 32'h0100_0193 + 32'h9E37_79B9;
    endfunction

    assign din_i = pattern(cnt);

    pingpong_capture #(
        .MAX_BYTES (MAX_BYTES),
        .BUF_BYTES (BUF_BYTES),
        .DELAY_W   (DELAY_W)
    ) i_pingpong_capture (
        .clk, .rst_n, .start_i, .stop_i, .cfg_width_i, .cfg_delay_i,
        .din_i, .chan_ready_i, .push_o, .push_data_o, .push_chan_o,
        .buf_end_o, .done_o, .overflow_o
    );

    always @(negedge clk) begin
        if (push_o && midx < 512) begin
            mdata[midx] <= push_data_o;
            mchan[midx] <= push_chan_o;
            mend[midx]  <= buf_end_o;
            midx        <= midx + 1;
        end
        cnt <= cnt + 1;
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_start(output int unsigned c0, output int base);
        tick();
        start_i = 1'b1;
        c0 = cnt;
        base = midx;
        tick();
        start_i = 1'b0;
    endtask

    task automatic t_reset();
        chk(!push_o && !done_o && !overflow_o, "R1", "outputs after reset",
            {push_o, done_o, overflow_o}, 0);
        repeat (3) tick();
        chk(!push_o && !done_o, "R1", "quiet before start", {push_o, done_o}, 0);
    endtask

    task automatic t_run(int w, int d, int k, string dreq);
        int unsigned c0;
        int base, n, guard, err_data, err_chan, err_end;
        logic [31:0] msk;
        n = BUF_BYTES / (w + 1);
        msk = '0;
        for (int b = 0; b <= w; b++) msk[8*b +: 8] = 8'hFF;
        chan_ready_i = 2'b11;
        cfg_width_i = 2'(w);
        cfg_delay_i = 16'(d);
        pulse_start(c0, base);
        chk(!overflow_o && !done_o, "R10", "flags cleared by start",
            {overflow_o, done_o}, 0);
        guard = 0;
        while (midx - base < k && guard < 2000) begin
            tick();
            guard++;
        end
        chk(!done_o, "R10", "done low while running", done_o, 0);
        stop_i = 1'b1;
        tick();
        stop_i = 1'b0;
        chk(done_o && !push_o && !overflow_o, "R9", "stop halts",
            {done_o, push_o, overflow_o}, 3'b100);
        repeat (4) tick();
        chk(midx - base == k, "R9", "word count after stop", midx - base, k);
        chk(mdata[base] == (pattern(c0 + d + 1) & msk), dreq, "first word alignment",
            mdata[base], pattern(c0 + d + 1) & msk);
        chk((mdata[base] & ~msk) == 0, "R2", "upper bytes zero", mdata[base] & ~msk, 0);
        err_data = 0; err_chan = 0; err_end = 0;
        for (int i = 0; i < k; i++) begin
            if (mdata[base+i] != (pattern(c0 + d + 1 + i) & msk)) err_data++;
            if (mchan[base+i] != 1'((i / n) % 2)) err_chan++;
            if (mend[base+i] != ((i % n) == n - 1)) err_end++;
        end
        chk(err_data == 0, "R11", "contiguous words", err_data, 0);
        chk(err_chan == 0, "R4", "channel order", err_chan, 0);
        chk(err_end == 0, "R3", "buffer end positions", err_end, 0);
    endtask

    task automatic t_overflow();
        int unsigned c0;
        int base, bad;
        chan_ready_i = 2'b01;
        cfg_width_i = 2'd3;
        cfg_delay_i = 16'd0;
        pulse_start(c0, base);
        repeat (30) tick();
        chk(midx - base == 6, "R8", "words before overflow", midx - base, 6);
        chk(done_o && overflow_o && !push_o, "R8", "overflow halt",
            {done_o, overflow_o, push_o}, 3'b110);
        bad = 0;
        for (int i = 0; i < 6; i++) if (mchan[base+i] != 1'b0) bad++;
        chk(bad == 0, "R4", "first buffer on channel 0", bad, 0);
        chan_ready_i = 2'b11;
    endtask

    task automatic t_stop_in_delay();
        int unsigned c0;
        int base;
        cfg_width_i = 2'd0;
        cfg_delay_i = 16'd20;
        pulse_start(c0, base);
        repeat (5) tick();
        stop_i = 1'b1;
        tick();
        stop_i = 1'b0;
        repeat (30) tick();
        chk(midx - base == 0, "R9", "no words after stop in delay", midx - base, 0);
        chk(done_o && !overflow_o, "R9", "stop flags", {done_o, overflow_o}, 2'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_run(0, 0, 51, "R5");
        t_run(1, 1, 36, "R6");
        t_run(3, 5, 26, "R7");
        t_run(2, 2, 17, "R7");
        t_overflow();
        t_run(1, 0, 25, "R5");
        t_stop_in_delay();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
        $finish;
    end

endmodule